// File: doc/BRIEF.md
# Interrupt Stack Sequencer

This block produces the bus cycles an 8-bit processor with a 16-bit address space needs when it takes an interrupt and when it returns from one. Interrupt request pulses are held in per-line latches. At an instruction boundary, if the mask bit in the condition-code byte is clear and at least one request is held, the block picks the lowest-numbered pending line. It locks that choice in and starts an entry sequence.

The entry sequence writes one byte per cycle onto a stack that grows downward. The bytes are the return address (current PC minus one), then the index byte, the accumulator and the condition-code byte. The block then sets the mask bit and reads a two-byte vector, high byte first. In the last cycle it fetches the first opcode at that address. A return sequence, started by a strobe, reads the same five bytes back from rising stack addresses in the reverse order and then fetches at the restored PC. A busy flag stalls the surrounding fetch logic for the whole of either sequence. An update strobe in the final cycle tells the register file to load the resulting PC, SP, A, X and CCR.

Top module: `irq_stack_seq`

## Requirements
- R1: While reset is asserted, and in the first idle cycles after it, `busy`, `upd` and `ack` are all low, and no request is pending. An instruction boundary with the mask clear therefore starts no sequence.
- R2: An entry sequence starts only from idle, in the cycle after a sampling edge where `insn_bound` is high, bit 3 of `ccr_in` (the mask bit) is 0 and a request is held. With the mask set, or with no boundary, nothing starts.
- R3: A one-cycle pulse on `irq_req[i]` is held until that line is acknowledged. After the acknowledge, line i is no longer pending.
- R4: When several lines are held at the sampling edge, the one with the lowest index is served.
- R5: Once a line has been selected, requests that arrive during the sequence, of any priority, do not change the vector fetched. They stay pending for a later boundary.
- R6: Entry writes one byte per cycle with `rw`=0: the low byte of PC-1 at SP, the high byte of PC-1 at SP-1, X at SP-2, A at SP-3 and CCR (as given) at SP-4. The first write comes in the cycle after the accepting edge.
- R7: After the pushes, the block reads the vector high byte at 0xFFFE-2*i and then the low byte at 0xFFFF-2*i, with `rw`=1. `ack` is one-hot with bit i set only during the high-byte read.
- R8: The cycle after the vector reads is a read at the vector address with `upd`=1. In that cycle `pc_out` is the vector, `sp_out` is SP-5, `ccr_out` is the entry CCR with bit 3 set, and `a_out`/`x_out` equal the entry A and X.
- R9: A return (`rti_start` while idle) reads CCR at SP+1, A at SP+2, X at SP+3, the PC high byte at SP+4 and the PC low byte at SP+5, one per cycle. It then reads at the restored PC with `upd`=1 and `sp_out`=SP+5, and the popped CCR (mask bit included) appears on `ccr_out`.
- R10: If `rti_start` and an acceptable interrupt arrive on the same edge, the return runs and the request stays pending.
- R11: `busy` is high in every cycle from the first stack access through the final fetch cycle, and low when idle. Boundaries seen while busy start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NREQ | Request pulses, one per line |
| insn_bound | input | 1 | Instruction boundary strobe |
| rti_start | input | 1 | Start a return sequence |
| pc_in | input | 2*DW | Current program counter |
| sp_in | input | 2*DW | Current stack pointer |
| a_in | input | DW | Current accumulator |
| x_in | input | DW | Current index byte |
| ccr_in | input | DW | Current condition-code byte |
| din | input | DW | Read data from memory |
| addr | output | 2*DW | Bus address |
| dout | output | DW | Write data |
| rw | output | 1 | 1 = read, 0 = write |
| busy | output | 1 | Sequence in progress |
| upd | output | 1 | Final cycle; register outputs valid |
| ack | output | NREQ | One-hot acknowledge of the served line |
| pc_out | output | 2*DW | New program counter |
| sp_out | output | 2*DW | New stack pointer |
| a_out | output | DW | New accumulator |
| x_out | output | DW | New index byte |
| ccr_out | output | DW | New condition-code byte |

## Verification
A bad state step or stack-pointer slip shows at the ports within one cycle. It appears as a wrong address or data byte on the next bus cycle, and after that as a wrong `sp_out` in the fetch cycle. A bad latch or lock shows as the wrong vector address in the sixth cycle of entry, or as a sequence that starts or fails to start at a later boundary. The bench sweeps every line over several PC and SP values, including a PC of zero whose return address wraps. Each entry is paired with a return so that stacked bytes travel through memory and back.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PUSH_PCL,
      ST_PUSH_PCH,
      ST_PUSH_X,
      ST_PUSH_A,
      ST_PUSH_CCR,
      ST_VEC_HI,
      ST_VEC_LO,
      ST_POP_CCR,
      ST_POP_A,
      ST_POP_X,
      ST_POP_PCH,
      ST_POP_PCL,
      ST_FETCH
   } seq_state_e;

endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
   parameter int NREQ           = 4,
   parameter bit LOW_INDEX_WINS = 1'b1,
   localparam int IW            = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] req,
   input  logic            take,
   input  logic            ack_fire,
   output logic            any_pend,
   output logic [IW-1:0]   sel_idx,
   output logic [NREQ-1:0] ack
);

   logic [NREQ-1:0] pend_q;
   logic [IW-1:0]   enc;
   logic [IW-1:0]   sel_q;
   logic            lock_q;

   generate
      if (LOW_INDEX_WINS) begin : g_low_wins
         always_comb begin
            enc = '0;
            for (int i = NREQ - 1; i >= 0; i--) begin
               if (pend_q[i]) enc = IW'(i);
            end
         end
      end else begin : g_high_wins
         always_comb begin
            enc = '0;
            for (int i = 0; i < NREQ; i++) begin
               if (pend_q[i]) enc = IW'(i);
            end
         end
      end
   endgenerate

   always_comb begin
      ack = '0;
      if (ack_fire) ack[sel_q] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         sel_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~ack) | req;
         if (take) begin
            sel_q  <= enc;
            lock_q <= 1'b1;
         end else if (ack_fire) begin
            lock_q <= 1'b0;
         end
      end
   end

   assign any_pend = |pend_q;
   assign sel_idx  = sel_q;

   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) (ack != '0) |-> ($onehot(ack) && ((ack & pend_q) != '0))) else $error("ack not one-hot on a held line"); // R7
   AST_LOCKED_HELD: assert property (@(posedge clk) disable iff (!rst_n) lock_q |-> pend_q[sel_q]) else $error("locked line lost before service"); // R5
   AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) take |-> pend_q[enc]) else $error("selection of an idle line"); // R4

endmodule

// File: rtl/irq_stack_fsm.sv
module irq_stack_fsm
   import irq_seq_pkg::*;
#(
   parameter int          DW      = 8,
   parameter int          IW      = 2,
   parameter int unsigned VEC_TOP = 32'hFFFE,
   parameter int          I_BIT   = 3,
   localparam int         AW      = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          insn_bound,
   input  logic          rti_start,
   input  logic          any_pend,
   input  logic [IW-1:0] sel_idx,
   input  logic [AW-1:0] pc_in,
   input  logic [AW-1:0] sp_in,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] ccr_in,
   input  logic [DW-1:0] din,
   output logic          take,
   output logic          ack_fire,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] dout,
   output logic          rw,
   output logic          busy,
   output logic          upd,
   output logic [AW-1:0] pc_out,
   output logic [AW-1:0] sp_out,
   output logic [DW-1:0] a_out,
   output logic [DW-1:0] x_out,
   output logic [DW-1:0] ccr_out
);

   localparam logic [AW-1:0] VTOP = AW'(VEC_TOP);

   seq_state_e    state;
   logic [AW-1:0] sp_r;
   logic [AW-1:0] pc_r;
   logic [DW-1:0] a_r;
   logic [DW-1:0] x_r;
   logic [DW-1:0] ccr_r;
   logic [AW-1:0] vec;
   logic [AW-1:0] sp_up;

   assign vec   = VTOP - (AW'(sel_idx) << 1);
   assign sp_up = sp_r + AW'(1);
   assign take  = (state == ST_IDLE) && !rti_start && insn_bound && !ccr_in[I_BIT] && any_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         sp_r  <= '0;
         pc_r  <= '0;
         a_r   <= '0;
         x_r   <= '0;
         ccr_r <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (rti_start) begin
                  sp_r  <= sp_in;
                  state <= ST_POP_CCR;
               end else if (take) begin
                  sp_r  <= sp_in;
                  pc_r  <= pc_in - AW'(1);
                  a_r   <= a_in;
                  x_r   <= x_in;
                  ccr_r <= ccr_in;
                  state <= ST_PUSH_PCL;
               end
            end
            ST_PUSH_PCL: begin sp_r <= sp_r - AW'(1); state <= ST_PUSH_PCH; end
            ST_PUSH_PCH: begin sp_r <= sp_r - AW'(1); state <= ST_PUSH_X;   end
            ST_PUSH_X:   begin sp_r <= sp_r - AW'(1); state <= ST_PUSH_A;   end
            ST_PUSH_A:   begin sp_r <= sp_r - AW'(1); state <= ST_PUSH_CCR; end
            ST_PUSH_CCR: begin
               sp_r         <= sp_r - AW'(1);
               ccr_r[I_BIT] <= 1'b1;
               state        <= ST_VEC_HI;
            end
            ST_VEC_HI: begin pc_r[AW-1:DW] <= din; state <= ST_VEC_LO; end
            ST_VEC_LO: begin pc_r[DW-1:0]  <= din; state <= ST_FETCH;  end
            ST_POP_CCR: begin sp_r <= sp_up; ccr_r <= din;          state <= ST_POP_A;   end
            ST_POP_A:   begin sp_r <= sp_up; a_r   <= din;          state <= ST_POP_X;   end
            ST_POP_X:   begin sp_r <= sp_up; x_r   <= din;          state <= ST_POP_PCH; end
            ST_POP_PCH: begin sp_r <= sp_up; pc_r[AW-1:DW] <= din;  state <= ST_POP_PCL; end
            ST_POP_PCL: begin sp_r <= sp_up; pc_r[DW-1:0]  <= din;  state <= ST_FETCH;   end
            default:    state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      addr = '0;
      dout = '0;
      rw   = 1'b1;
      case (state)
         ST_PUSH_PCL: begin addr = sp_r; dout = pc_r[DW-1:0];  rw = 1'b0; end
         ST_PUSH_PCH: begin addr = sp_r; dout = pc_r[AW-1:DW]; rw = 1'b0; end
         ST_PUSH_X:   begin addr = sp_r; dout = x_r;           rw = 1'b0; end
         ST_PUSH_A:   begin addr = sp_r; dout = a_r;           rw = 1'b0; end
         ST_PUSH_CCR: begin addr = sp_r; dout = ccr_r;         rw = 1'b0; end
         ST_VEC_HI:   addr = vec;
         ST_VEC_LO:   addr = vec + AW'(1);
         ST_POP_CCR, ST_POP_A, ST_POP_X, ST_POP_PCH, ST_POP_PCL: addr = sp_up;
         ST_FETCH:    addr = pc_r;
         default:     addr = '0;
      endcase
   end

   assign busy     = (state != ST_IDLE);
   assign upd      = (state == ST_FETCH);
   assign ack_fire = (state == ST_VEC_HI);
   assign pc_out   = pc_r;
   assign sp_out   = sp_r;
   assign a_out    = a_r;
   assign x_out    = x_r;
   assign ccr_out  = ccr_r;

   AST_SP_DOWN_FIVE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_VEC_HI) |-> (sp_r == $past(sp_r, 5) - AW'(5))) else $error("stack pointer off after pushes"); // R6
   AST_MASK_ON_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_VEC_HI) |-> ccr_r[I_BIT]) else $error("mask bit clear at vector read"); // R8
   AST_SP_UP_FIVE: assert property (@(posedge clk) disable iff (!rst_n) ((state == ST_FETCH) && ($past(state) == ST_POP_PCL)) |-> (sp_r == $past(sp_r, 5) + AW'(5))) else $error("stack pointer off after pops"); // R9
   AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_PUSH_PCL) |-> ($past(insn_bound) && !$past(ccr_in[I_BIT]) && $past(any_pend) && !$past(rti_start))) else $error("entry without a legal boundary"); // R2
   AST_RETURN_FIRST: assert property (@(posedge clk) disable iff (!rst_n) ((state == ST_POP_CCR) && ($past(state) == ST_IDLE)) |-> $past(rti_start)) else $error("return without a strobe"); // R10

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq #(
   parameter int          DW             = 8,
   parameter int          NREQ           = 4,
   parameter int unsigned VEC_TOP        = 32'hFFFE,
   parameter int          I_BIT          = 3,
   parameter bit          LOW_INDEX_WINS = 1'b1,
   localparam int         AW             = 2 * DW,
   localparam int         IW             = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] irq_req,
   input  logic            insn_bound,
   input  logic            rti_start,
   input  logic [AW-1:0]   pc_in,
   input  logic [AW-1:0]   sp_in,
   input  logic [DW-1:0]   a_in,
   input  logic [DW-1:0]   x_in,
   input  logic [DW-1:0]   ccr_in,
   input  logic [DW-1:0]   din,
   output logic [AW-1:0]   addr,
   output logic [DW-1:0]   dout,
   output logic            rw,
   output logic            busy,
   output logic            upd,
   output logic [NREQ-1:0] ack,
   output logic [AW-1:0]   pc_out,
   output logic [AW-1:0]   sp_out,
   output logic [DW-1:0]   a_out,
   output logic [DW-1:0]   x_out,
   output logic [DW-1:0]   ccr_out
);

   generate
      if (DW < 4 || DW > 16) begin : g_bad_width
         $error("DW must lie in 4..16");
      end
      if (NREQ < 1) begin : g_bad_lines
         $error("NREQ must be at least 1");
      end
      if (I_BIT < 0 || I_BIT >= DW) begin : g_bad_mask
         $error("I_BIT must select a bit of the condition byte");
      end
      if (VEC_TOP < 2 * (NREQ - 1) || VEC_TOP >= (64'd1 << AW) - 1) begin : g_bad_vec
         $error("vector table does not fit below VEC_TOP");
      end
   endgenerate

   logic          take;
   logic          ack_fire;
   logic          any_pend;
   logic [IW-1:0] sel_idx;

   irq_pend_arb #(
      .NREQ           (NREQ),
      .LOW_INDEX_WINS (LOW_INDEX_WINS)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (irq_req),
      .take     (take),
      .ack_fire (ack_fire),
      .any_pend (any_pend),
      .sel_idx  (sel_idx),
      .ack      (ack)
   );

   irq_stack_fsm #(
      .DW      (DW),
      .IW      (IW),
      .VEC_TOP (VEC_TOP),
      .I_BIT   (I_BIT)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_bound (insn_bound),
      .rti_start  (rti_start),
      .any_pend   (any_pend),
      .sel_idx    (sel_idx),
      .pc_in      (pc_in),
      .sp_in      (sp_in),
      .a_in       (a_in),
      .x_in       (x_in),
      .ccr_in     (ccr_in),
      .din        (din),
      .take       (take),
      .ack_fire   (ack_fire),
      .addr       (addr),
      .dout       (dout),
      .rw         (rw),
      .busy       (busy),
      .upd        (upd),
      .pc_out     (pc_out),
      .sp_out     (sp_out),
      .a_out      (a_out),
      .x_out      (x_out),
      .ccr_out    (ccr_out)
   );

   AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (ack == '0)) else $error("acknowledge outside a sequence"); // R7
   AST_UPD_ENDS: assert property (@(posedge clk) disable iff (!rst_n) upd |=> !busy) else $error("sequence did not end after update"); // R11
   AST_IDLE_READS: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> rw) else $error("write outside a sequence"); // R11

endmodule

// File: tb/irq_stack_seq_bench.sv
`timescale 1ns/1ps
module irq_stack_seq_bench;

   localparam int NREQ = 4;
   localparam logic [15:0] VT = 16'hFFFE;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NREQ-1:0] irq_req = '0;
   logic            insn_bound = 1'b0;
   logic            rti_start = 1'b0;
   logic [15:0]     pc_in = '0;
   logic [15:0]     sp_in = '0;
   logic [7:0]      a_in = '0;
   logic [7:0]      x_in = '0;
   logic [7:0]      ccr_in = '0;
   logic [7:0]      din;
   logic [15:0]     addr;
   logic [7:0]      dout;
   logic            rw;
   logic            busy;
   logic            upd;
   logic [NREQ-1:0] ack;
   logic [15:0]     pc_out;
   logic [15:0]     sp_out;
   logic [7:0]      a_out;
   logic [7:0]      x_out;
   logic [7:0]      ccr_out;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_stack_seq u_irq_stack_seq (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_bound(insn_bound),
      .rti_start(rti_start), .pc_in(pc_in), .sp_in(sp_in), .a_in(a_in),
      .x_in(x_in), .ccr_in(ccr_in), .din(din), .addr(addr), .dout(dout),
      .rw(rw), .busy(busy), .upd(upd), .ack(ack), .pc_out(pc_out),
      .sp_out(sp_out), .a_out(a_out), .x_out(x_out), .ccr_out(ccr_out)
   );

   logic [7:0] mem [0:511];

   function automatic int mslot(input logic [15:0] a);
      return int'({a[15], a[7:0]});
   endfunction

   assign din = mem[mslot(addr)];

   always @(posedge clk) begin
      if (busy && !rw) mem[mslot(addr)] <= dout;
   end

   function automatic logic [15:0] vec_of(input int idx);
      return VT - 16'(2 * idx);
   endfunction

   function automatic logic [15:0] start_of(input int idx);
      return {8'h40 + 8'(idx), 8'h11 * 8'(idx) + 8'h05};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic pulse_req(input logic [NREQ-1:0] m);
      irq_req = m;
      @(negedge clk);
      irq_req = '0;
   endtask

   task automatic do_entry(input int idx, input logic [15:0] pc, input logic [15:0] sp,
                           input logic [7:0] a, input logic [7:0] x, input logic [7:0] ccr,
                           input logic [NREQ-1:0] inj);
      logic [15:0] stk;
      logic [7:0]  bytes [5];
      logic [15:0] st;
      stk = pc - 16'd1;
      bytes[0] = stk[7:0]; bytes[1] = stk[15:8]; bytes[2] = x; bytes[3] = a; bytes[4] = ccr;
      st = start_of(idx);
      pc_in = pc; sp_in = sp; a_in = a; x_in = x; ccr_in = ccr;
      insn_bound = 1'b1;
      @(negedge clk);
      insn_bound = 1'b1;
      irq_req = inj;
      for (int k = 0; k < 5; k++) begin
         chk("R11 busy during push", busy, 1);
         chk("R6 push rw", rw, 0);
         chk("R6 push addr", addr, sp - 16'(k));
         chk("R6 push data", dout, bytes[k]);
         @(negedge clk);
         irq_req = '0;
      end
      chk("R7 vec hi addr R5", addr, vec_of(idx));
      chk("R7 vec hi rw", rw, 1);
      chk("R7 ack onehot R4", ack, NREQ'(1) << idx);
      @(negedge clk);
      chk("R7 vec lo addr", addr, vec_of(idx) + 16'd1);
      chk("R7 ack low", ack, 0);
      insn_bound = 1'b0;
      @(negedge clk);
      chk("R8 upd", upd, 1);
      chk("R8 fetch addr", addr, st);
      chk("R8 fetch rw", rw, 1);
      chk("R8 pc_out", pc_out, st);
      chk("R8 sp_out", sp_out, sp - 16'd5);
      chk("R8 ccr_out", ccr_out, ccr | 8'h08);
      chk("R8 a_out", a_out, a);
      chk("R8 x_out", x_out, x);
      chk("R11 busy in fetch", busy, 1);
      @(negedge clk);
      chk("R11 idle after entry", busy, 0);
      chk("R11 upd low", upd, 0);
   endtask

   task automatic do_return(input logic [15:0] sp, input logic [15:0] pc_exp,
                            input logic [7:0] a, input logic [7:0] x, input logic [7:0] ccr,
                            input logic bound);
      logic [7:0] exp_b [5];
      exp_b[0] = ccr; exp_b[1] = a; exp_b[2] = x; exp_b[3] = pc_exp[15:8]; exp_b[4] = pc_exp[7:0];
      sp_in = sp; ccr_in = 8'h00; rti_start = 1'b1; insn_bound = bound;
      @(negedge clk);
      rti_start = 1'b0; insn_bound = 1'b0;
      for (int k = 0; k < 5; k++) begin
         chk("R9 pop addr R10", addr, sp + 16'(k + 1));
         chk("R9 pop rw", rw, 1);
         chk("R9 pop data", din, exp_b[k]);
         chk("R11 busy during pop", busy, 1);
         @(negedge clk);
      end
      chk("R9 upd", upd, 1);
      chk("R9 resume addr", addr, pc_exp);
      chk("R9 pc_out", pc_out, pc_exp);
      chk("R9 sp_out", sp_out, sp + 16'd5);
      chk("R9 ccr_out mask restored", ccr_out, ccr);
      chk("R9 a_out", a_out, a);
      chk("R9 x_out", x_out, x);
      @(negedge clk);
      chk("R11 idle after return", busy, 0);
   endtask

   task automatic expect_no_start(input string tag, input logic [7:0] ccr, input logic bound);
      ccr_in = ccr; insn_bound = bound;
      @(negedge clk);
      insn_bound = 1'b0;
      chk(tag, busy, 0);
      @(negedge clk);
      chk(tag, busy, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      summary();
   end

   initial begin
      logic [15:0] pcs [4];
      logic [15:0] sps [2];
      pcs[0] = 16'h0000; pcs[1] = 16'h1234; pcs[2] = 16'h8001; pcs[3] = 16'hFFFF;
      sps[0] = 16'h00FF; sps[1] = 16'h0090;
      for (int i = 0; i < 512; i++) mem[i] = 8'h00;
      for (int i = 0; i < NREQ; i++) begin
         mem[mslot(vec_of(i))]         = start_of(i)[15:8];
         mem[mslot(vec_of(i) + 16'd1)] = start_of(i)[7:0];
      end
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", busy, 0);
      chk("R1 upd in reset", upd, 0);
      chk("R1 ack in reset", ack, 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_no_start("R1 nothing pending", 8'h00, 1'b1);

      // full sweep: every line, several PC and SP values, entry then return
      for (int i = 0; i < NREQ; i++) begin
         for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
               logic [7:0] a, x, c;
               a = 8'hA0 + 8'(p * 4 + i);
               x = 8'h5C ^ 8'(s * 16 + i);
               c = 8'hC1 ^ 8'(i);
               pulse_req(NREQ'(1) << i);
               do_entry(i, pcs[p], sps[s], a, x, c, '0);
               do_return(sps[s] - 16'd5, pcs[p] - 16'd1, a, x, c, 1'b0);
            end
         end
      end

      // R2 masked / no boundary, R3 held until served then cleared
      pulse_req(4'b0100);
      expect_no_start("R2 masked boundary", 8'h08, 1'b1);
      expect_no_start("R2 no boundary", 8'h00, 1'b0);
      do_entry(2, 16'h2222, 16'h00F0, 8'h12, 8'h34, 8'h40, '0);
      expect_no_start("R3 cleared after ack", 8'h00, 1'b1);
      do_return(16'h00EB, 16'h2221, 8'h12, 8'h34, 8'h40, 1'b0);

      // R4 priority among several held lines
      pulse_req(4'b1110);
      do_entry(1, 16'h3000, 16'h00E0, 8'h01, 8'h02, 8'h03, '0);
      do_return(16'h00DB, 16'h2FFF, 8'h01, 8'h02, 8'h03, 1'b0);
      do_entry(2, 16'h3100, 16'h00E0, 8'h04, 8'h05, 8'h06, '0);
      do_return(16'h00DB, 16'h30FF, 8'h04, 8'h05, 8'h06, 1'b0);
      do_entry(3, 16'h3200, 16'h00E0, 8'h07, 8'h08, 8'h81, '0);
      do_return(16'h00DB, 16'h31FF, 8'h07, 8'h08, 8'h81, 1'b0);
      expect_no_start("R4 all served", 8'h00, 1'b1);

      // R5 lock: higher-priority line arrives during entry of line 3
      pulse_req(4'b1000);
      do_entry(3, 16'h4444, 16'h00C8, 8'h99, 8'h88, 8'h20, 4'b0001);
      do_return(16'h00C3, 16'h4443, 8'h99, 8'h88, 8'h20, 1'b0);
      do_entry(0, 16'h5555, 16'h00C8, 8'h77, 8'h66, 8'h10, '0);
      do_return(16'h00C3, 16'h5554, 8'h77, 8'h66, 8'h10, 1'b0);

      // R10 return strobe beats a simultaneous acceptable interrupt
      pulse_req(4'b0010);
      do_entry(1, 16'h6000, 16'h00B0, 8'h3C, 8'h4D, 8'h02, '0);
      pulse_req(4'b0100);
      do_return(16'h00AB, 16'h5FFF, 8'h3C, 8'h4D, 8'h02, 1'b1);
      do_entry(2, 16'h7000, 16'h00B0, 8'h5E, 8'h6F, 8'h00, '0);
      do_return(16'h00AB, 16'h6FFF, 8'h5E, 8'h6F, 8'h00, 1'b0);

      summary();
   end

endmodule